// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block holds the time of day and the calendar date in eight byte-wide packed-BCD registers: seconds, minutes, hours, day of month, month, weekday, two-digit year and a control byte. An external prescaler supplies a single-cycle enable once per second. On each enable the seconds advance, and carries ripple through minutes, hours, date, month and year in the same clock edge. Month lengths and leap years are handled, and the hour register can count in either a 24-hour or a 12-hour AM/PM format.

A host reaches the registers through a plain indexed port. A write lands on the next clock edge. A read is combinational from the index. A halt flag in the seconds register freezes the count so that software can set the time. A write-protect bit in the control byte locks the time registers against stray writes.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds (bits 6..0) and minutes count 00 to 59 in packed BCD, tens digit in the upper nibble. A tick at 59 loads 00 and advances the next register on the same edge.
- R2: Bit 7 of the seconds register is a halt flag. While it is 1, ticks change no register. After the host writes it back to 0, ticks resume from the stored seconds value.
- R3: Bit 7 of the hours register set to 0 selects 24-hour mode. In that mode bits 5..0 count 00 to 23, and 23 wraps to 00, advancing the date.
- R4: Bit 7 of the hours register set to 1 selects 12-hour mode. Bit 5 is the PM flag and bits 4..0 count 01 to 12. Hour 11 steps to 12 and inverts PM, and hour 12 steps to 01. Leaving 11 PM (to 12 AM) advances the date.
- R5: The date counts 01 up to the month length, then wraps to 01 and advances the month. April, June, September and November have 30 days. February has 28 days, or 29 in a leap year. All other months have 31 days.
- R6: A year is a leap year when its BCD value, taken as a number 0 to 99, is divisible by 4. Year 00 is a leap year.
- R7: The month counts 01 to 12. Month 12 wraps to 01 and advances the year. The year counts 00 to 99 and wraps to 00.
- R8: The weekday advances with every date change and runs 01 to 07, with 07 wrapping to 01.
- R9: Index 7 is the control byte. Its bit 7 is write protect, and bits 6..0 always read 0. While write protect is 1, host writes to indices 0 to 6 are discarded. The control byte itself stays writable.
- R10: When a host write and a tick-driven update hit the same register on the same edge, the written value is stored.
- R11: After reset the registers read: seconds 00 and running, minutes 00, hours 00 in 24-hour mode, date 01, month 01, weekday 01, year 00, control 00.
- R12: Register indices are fixed: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday, 6 year, 7 control. A write is visible on the read port after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle enable, once per second |
| wrEn | input | 1 | Host write strobe |
| wrIdx | input | 3 | Register index for the write |
| wrData | input | 8 | Write data |
| rdIdx | input | 3 | Register index for the read |
| rdData | output | 8 | Read data for rdIdx |

## Verification
The hardest states to reach from the ports are the month and year boundaries. In free-running time they are months or decades apart, so ticking into them is not practical. The bench loads each state directly: for every year 00 to 99 and every month, it writes 23:59:59 with the date set one day before and exactly on the month end, then applies a single tick. This covers every month-length and leap-year outcome, and every weekday, month and year carry. Full 24-hour sweeps and both 12-hour noon and midnight crossings are ticked through cycle by cycle.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;
  localparam int NUM_REGS = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IDX_SEC   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_MIN   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_HOUR  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DATE  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MONTH = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DOW   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_YEAR  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic stepSec;
    logic stepMin;
    logic stepHour;
    logic stepDay;
    logic stepMonth;
    logic stepYear;
    logic secEnd;
    logic minEnd;
    logic dateEnd;
    logic dowEnd;
    logic monthEnd;
    logic yearEnd;
  } stepCtl_t;

  function automatic logic [DATA_W-1:0] bcdInc(input logic [DATA_W-1:0] v);
    if (v[3:0] >= 4'h9) bcdInc = {v[7:4] + 4'h1, 4'h0};
    else                bcdInc = {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [DATA_W-1:0] v);
    bcdToBin = ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  function automatic logic leapYear(input logic [DATA_W-1:0] yr);
    logic [6:0] b;
    b = bcdToBin(yr);
    leapYear = (b[1:0] == 2'b00);
  endfunction

  function automatic logic [DATA_W-1:0] monthDays(input logic [DATA_W-1:0] mon,
                                                  input logic [DATA_W-1:0] yr);
    case (mon)
      8'h02:                      monthDays = leapYear(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: monthDays = 8'h30;
      default:                    monthDays = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
`timescale 1ns/1ps
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              secTick,
  input  logic              haltFlag,
  input  logic [6:0]        secLow,
  input  logic [6:0]        minLow,
  input  logic              hourMode12,
  input  logic [5:0]        hourLow,
  input  logic [DATA_W-1:0] dateVal,
  input  logic [DATA_W-1:0] monthVal,
  input  logic [DATA_W-1:0] dowVal,
  input  logic [DATA_W-1:0] yearVal,
  output stepCtl_t          steps
);
  logic advance;
  logic hourEnd;
  logic [DATA_W-1:0] lastDay;

  always_comb begin
    advance = secTick & ~haltFlag;
    lastDay = monthDays(monthVal, yearVal);
    // 12-hour: day ends when leaving 11 PM; 24-hour: when leaving 23
    if (hourMode12) hourEnd = hourLow[5] && (hourLow[4:0] == 5'h11);
    else            hourEnd = (hourLow == 6'h23);

    steps.secEnd   = (secLow == 7'h59);
    steps.minEnd   = (minLow == 7'h59);
    steps.dateEnd  = (dateVal >= lastDay);
    steps.dowEnd   = (dowVal >= 8'h07);
    steps.monthEnd = (monthVal >= 8'h12);
    steps.yearEnd  = (yearVal == 8'h99);

    steps.stepSec   = advance;
    steps.stepMin   = advance & steps.secEnd;
    steps.stepHour  = steps.stepMin & steps.minEnd;
    steps.stepDay   = steps.stepHour & hourEnd;
    steps.stepMonth = steps.stepDay & steps.dateEnd;
    steps.stepYear  = steps.stepMonth & steps.monthEnd;
  end
endmodule

// File: rtl/rtc_cal_datapath.sv
`timescale 1ns/1ps
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          steps,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] secReg,
  output logic [DATA_W-1:0] minReg,
  output logic [DATA_W-1:0] hourReg,
  output logic [DATA_W-1:0] dateReg,
  output logic [DATA_W-1:0] monthReg,
  output logic [DATA_W-1:0] dowReg,
  output logic [DATA_W-1:0] yearReg
);
  logic wpReg;
  logic wrAllowed;
  logic [NUM_REGS-1:0] wrHit;
  logic [DATA_W-1:0] secNext, minNext, hourNext, dateNext, monthNext, dowNext, yearNext;
  logic [DATA_W-1:0] ctrlView;

  assign wrAllowed = wrEn && (wrIdx == IDX_CTRL || !wpReg);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_hit
      assign wrHit[gi] = wrAllowed && (wrIdx == IDX_W'(gi));
    end
  endgenerate

  always_comb begin
    secNext = steps.secEnd ? {secReg[7], 7'h00}
                           : (bcdInc({1'b0, secReg[6:0]}) | {secReg[7], 7'h00});
    minNext = steps.minEnd ? 8'h00 : bcdInc(minReg);
    if (hourReg[7]) begin
      if (hourReg[4:0] == 5'h12)
        hourNext = {2'b10, hourReg[5], 5'h01};
      else if (hourReg[4:0] == 5'h11)
        hourNext = {2'b10, ~hourReg[5], 5'h12};
      else
        hourNext = {2'b10, hourReg[5], 5'h00} | bcdInc({3'b000, hourReg[4:0]});
    end else begin
      hourNext = (hourReg[5:0] == 6'h23) ? 8'h00 : bcdInc({2'b00, hourReg[5:0]});
    end
    dateNext  = steps.dateEnd  ? 8'h01 : bcdInc(dateReg);
    dowNext   = steps.dowEnd   ? 8'h01 : bcdInc(dowReg);
    monthNext = steps.monthEnd ? 8'h01 : bcdInc(monthReg);
    yearNext  = steps.yearEnd  ? 8'h00 : bcdInc(yearReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg   <= 8'h00;
      minReg   <= 8'h00;
      hourReg  <= 8'h00;
      dateReg  <= 8'h01;
      monthReg <= 8'h01;
      dowReg   <= 8'h01;
      yearReg  <= 8'h00;
      wpReg    <= 1'b0;
    end else begin
      if (wrHit[IDX_SEC])        secReg <= wrData;
      else if (steps.stepSec)    secReg <= secNext;

      if (wrHit[IDX_MIN])        minReg <= wrData;
      else if (steps.stepMin)    minReg <= minNext;

      if (wrHit[IDX_HOUR])       hourReg <= wrData;
      else if (steps.stepHour)   hourReg <= hourNext;

      if (wrHit[IDX_DATE])       dateReg <= wrData;
      else if (steps.stepDay)    dateReg <= dateNext;

      if (wrHit[IDX_DOW])        dowReg <= wrData;
      else if (steps.stepDay)    dowReg <= dowNext;

      if (wrHit[IDX_MONTH])      monthReg <= wrData;
      else if (steps.stepMonth)  monthReg <= monthNext;

      if (wrHit[IDX_YEAR])       yearReg <= wrData;
      else if (steps.stepYear)   yearReg <= yearNext;

      if (wrHit[IDX_CTRL])       wpReg <= wrData[7];
    end
  end

  assign ctrlView = {wpReg, 7'h00};

  always_comb begin
    case (rdIdx)
      IDX_SEC:   rdData = secReg;
      IDX_MIN:   rdData = minReg;
      IDX_HOUR:  rdData = hourReg;
      IDX_DATE:  rdData = dateReg;
      IDX_MONTH: rdData = monthReg;
      IDX_DOW:   rdData = dowReg;
      IDX_YEAR:  rdData = yearReg;
      default:   rdData = ctrlView;
    endcase
  end

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steps.stepSec && secReg[6:0] == 7'h59 && !wrHit[IDX_SEC]) |=> secReg[6:0] == 7'h00);

  // R2
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secReg[7] && !wrHit[IDX_SEC]) |=> $stable(secReg));

  // R3
  hour_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit[IDX_HOUR] |=> $stable(hourReg[7]));

  // R5
  date_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steps.stepDay && steps.dateEnd && !wrHit[IDX_DATE]) |=> dateReg == 8'h01);

  // R8
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (steps.stepDay && dowReg == 8'h07 && !wrHit[IDX_DOW]) |=> dowReg == 8'h01);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wpReg && wrEn && wrIdx != IDX_CTRL && !steps.stepSec)
      |=> $stable({secReg, minReg, hourReg, dateReg, monthReg, dowReg, yearReg}));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == IDX_MIN && !wpReg) |=> minReg == $past(wrData));
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  stepCtl_t steps;
  logic [DATA_W-1:0] secReg, minReg, hourReg, dateReg, monthReg, dowReg, yearReg;

  rtc_cal_ctrl ctrl_i (
    .secTick    (secTick),
    .haltFlag   (secReg[7]),
    .secLow     (secReg[6:0]),
    .minLow     (minReg[6:0]),
    .hourMode12 (hourReg[7]),
    .hourLow    (hourReg[5:0]),
    .dateVal    (dateReg),
    .monthVal   (monthReg),
    .dowVal     (dowReg),
    .yearVal    (yearReg),
    .steps      (steps)
  );

  rtc_cal_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .steps    (steps),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .secReg   (secReg),
    .minReg   (minReg),
    .hourReg  (hourReg),
    .dateReg  (dateReg),
    .monthReg (monthReg),
    .dowReg   (dowReg),
    .yearReg  (yearReg)
  );
endmodule

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [2:0] rdIdx = 3'd0;
  logic [7:0] rdData;

  int nChk = 0;
  int nBad = 0;

  int mSec, mMin, mHour, mDate, mMonth, mDow, mYear;
  bit mode12;

  always #4 clk = ~clk;

  rtc_calendar dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData)
  );

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int daysIn(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expHour();
    int h;
    if (!mode12) return toBcd(mHour);
    h = mHour % 12;
    if (h == 0) h = 12;
    return 8'h80 | ((mHour >= 12) ? 8'h20 : 8'h00) | toBcd(h);
  endfunction

  function automatic logic [7:0] expReg(input int idx);
    case (idx)
      0: return toBcd(mSec);
      1: return toBcd(mMin);
      2: return expHour();
      3: return toBcd(mDate);
      4: return toBcd(mMonth);
      5: return toBcd(mDow);
      default: return toBcd(mYear);
    endcase
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mDow = (mDow == 7) ? 1 : mDow + 1;
          if (mDate >= daysIn(mMonth, mYear)) begin
            mDate = 1; mMonth++;
            if (mMonth == 13) begin
              mMonth = 1;
              mYear = (mYear + 1) % 100;
            end
          end else mDate++;
        end
      end
    end
  endtask

  task automatic chk(input int idx, input logic [7:0] exp, input string tag);
    rdIdx = 3'(idx);
    #0.2;
    nChk++;
    if (rdData !== exp) begin
      nBad++;
      $display("FAIL %s: index %0d actual %02h expected %02h", tag, idx, rdData, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    wrEn = 1'b1; wrIdx = 3'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickRaw();
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic tickOnce();
    tickRaw();
    modelTick();
  endtask

  task automatic loadAll();
    for (int i = 0; i < 7; i++) wr(i, expReg(i));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    mSec = 0; mMin = 0; mHour = 0; mDate = 1; mMonth = 1; mDow = 1; mYear = 0; mode12 = 0;
    for (int i = 0; i < 7; i++) chk(i, expReg(i), "R11 reset");
    chk(7, 8'h00, "R11 reset ctrl");

    // R1 R3: full 24-hour day, one register compared per tick
    for (int i = 0; i < 86400; i++) begin
      tickOnce();
      chk(i % 3, expReg(i % 3), (i % 3 == 2) ? "R3 hour24" : "R1 sec/min");
    end
    chk(3, 8'h02, "R3 date after day");
    chk(5, 8'h02, "R8 dow after day");

    // R4: 12-hour crossings of noon and midnight
    mode12 = 1;
    for (int seg = 0; seg < 2; seg++) begin
      mHour = (seg == 0) ? 11 : 23; mMin = 0; mSec = 0;
      loadAll();
      for (int i = 0; i < 7200; i++) begin
        tickOnce();
        chk(i % 3, expReg(i % 3), "R4 hour12");
      end
      chk(3, expReg(3), "R4 date in 12h");
    end
    mode12 = 0;

    // R5 R6 R7 R8: every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int k = 0; k < 2; k++) begin
          mYear = y; mMonth = m; mDate = daysIn(m, y) - 1 + k;
          mDow = ((y + m + k) % 7) + 1;
          mHour = 23; mMin = 59; mSec = 59;
          loadAll();
          tickOnce();
          chk(3, expReg(3), (m == 2) ? "R6 leap date" : "R5 date");
          chk(4, expReg(4), "R7 month");
          chk(6, expReg(6), "R7 year");
          chk(5, expReg(5), "R8 dow");
        end
      end
    end

    // R2 halt
    mSec = 30; mMin = 5; mHour = 10;
    loadAll();
    wr(0, 8'hB0);
    for (int i = 0; i < 5; i++) tickRaw();
    chk(0, 8'hB0, "R2 halted sec");
    chk(1, toBcd(mMin), "R2 halted min");
    wr(0, 8'h30);
    tickOnce();
    chk(0, 8'h31, "R2 resumed");

    // R9 write protect
    wr(7, 8'hFF);
    chk(7, 8'h80, "R9 ctrl low bits");
    wr(1, 8'h45);
    chk(1, toBcd(mMin), "R9 min blocked");
    wr(3, 8'h17);
    chk(3, toBcd(mDate), "R9 date blocked");
    wr(7, 8'h00);
    chk(7, 8'h00, "R9 ctrl cleared");
    wr(1, 8'h45); mMin = 45;
    chk(1, 8'h45, "R12 min written");

    // R10 write and carry on the same edge
    mSec = 59; mMin = 10;
    loadAll();
    wrEn = 1'b1; wrIdx = 3'd1; wrData = 8'h22; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    chk(0, 8'h00, "R10 sec wrapped");
    chk(1, 8'h22, "R10 min write wins");
    wrEn = 1'b1; wrIdx = 3'd0; wrData = 8'h15; secTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    chk(0, 8'h15, "R10 sec write wins");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule